// File: doc/BRIEF.md
# Double-Buffered Transmit Byte Serializer

This block sends bytes written by a host out on a single serial line at a programmable bit rate. Two byte registers take turns. The shifter sends one of them while the host refills the other. This lets the host keep the line busy without having to meet the timing of each bit. Both registers hold the alternating pattern 0xAA while the block is idle. When transmission is enabled, the line therefore opens with sixteen alternating bits that a receiver can lock onto.

The bit period is counted in cycles of the reference clock, and two inputs set it: a 7-bit rate value and a prescale bit. Two status outputs guide the host. The ready flag asks for the next byte. The sticky underrun flag reports two faults: the line ran dry, or a byte that had not yet been sent was replaced. When no fresh byte is waiting at the end of a byte, the block sends the last byte again instead of stopping the line.

Top module: `tx_pingpong_serializer`

## Requirements
- R1: After `tx_en` rises, the first two bytes sent are 0xAA from slot 0 and then 0xAA from slot 1. The first bit appears on the clock edge that samples `tx_en` high.
- R2: While `tx_en` is low, both slots return to 0xAA, `tx_bit` and `ready` are 0, and `wr_stb` has no effect on the bytes sent after the next enable.
- R3: Each byte goes out MSB first. Each bit lasts exactly 29·(rate_div+1)·(rate_pre ? 8 : 1) clock cycles.
- R4: A change of `rate_div` or `rate_pre` in the middle of a bit leaves the current bit at its old length. The new length applies from the next bit boundary.
- R5: `ready` rises in the cycle after the shifter takes a fresh byte from a slot. It falls in the cycle after a write.
- R6: After enable, host writes go to slot 0 first and then alternate between the slots. Bytes leave in the order they were written.
- R7: At the end of a byte, if the next slot holds no fresh byte, the byte last sent is sent again and `underrun` is set.
- R8: A write to a slot whose byte has not yet been sent replaces that byte and sets `underrun`.
- R9: A `flag_clr` pulse clears `underrun`. If a new fault occurs in the same cycle, the fault wins and the flag stays set.
- R10: A write to the slot that the shifter is emptying in that same cycle counts as a fresh byte. It does not set `underrun`, and `ready` stays clear.
- R11: During reset, `tx_bit`, `ready` and `underrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable; low re-initialises both slots |
| wr_stb | input | 1 | One-cycle byte write strobe |
| wr_byte | input | 8 | Byte to queue |
| rate_div | input | 7 | Rate value R |
| rate_pre | input | 1 | Prescale bit; multiplies the period by 8 |
| flag_clr | input | 1 | Status-read pulse; clears `underrun` |
| tx_bit | output | 1 | Serial data, MSB first |
| ready | output | 1 | A slot was freed and has not been written since |
| underrun | output | 1 | Sticky fault flag: data ran out, or an unsent byte was overwritten |

## Verification
The hardest coincidence is a host write that lands on the exact edge where the shifter empties the same slot. In that cycle the flag logic must decide between the write and the load. The bench places the strobe on the byte-boundary edge, which it computes as eight bit periods after the enable edge. It then checks that `underrun` stays clear and `ready` stays low, and that the written byte follows the preamble in order. A second coincidence puts a `flag_clr` pulse on the edge of a retransmission, and the bench expects the flag to remain set.

// File: rtl/tps_pkg.sv
package tps_pkg;
  localparam int unsigned TPS_SLOTS = 2;
  localparam int unsigned TPS_BASE_DIV = 29;
  localparam int unsigned TPS_PRE_MUL = 8;
endpackage

// File: rtl/tps_bit_clock.sv
module tps_bit_clock #(
  parameter int unsigned RW   = 7,
  parameter int unsigned BASE = tps_pkg::TPS_BASE_DIV,
  parameter int unsigned PRE  = tps_pkg::TPS_PRE_MUL
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          start,
  input  logic [RW-1:0] rate_div,
  input  logic          rate_pre,
  output logic          tick
);
  localparam int unsigned PMAX = BASE * (2 ** RW) * PRE;
  localparam int unsigned CW   = $clog2(PMAX + 1);

  logic [CW-1:0] cnt_q, cnt_d, period;

  assign period = CW'(BASE) * (CW'(rate_div) + CW'(1)) * (rate_pre ? CW'(PRE) : CW'(1));
  assign tick   = run && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (start) begin
      cnt_d = period - CW'(1);
    end else if (run) begin
      cnt_d = (cnt_q == '0) ? period - CW'(1) : cnt_q - CW'(1);
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/tps_shifter.sv
module tps_shifter #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          tick,
  input  logic [DW-1:0] next_byte,
  output logic          start,
  output logic          load,
  output logic          active,
  output logic          tx_bit
);
  localparam int unsigned IW = $clog2(DW);

  logic          act_q, act_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [IW-1:0] idx_q, idx_d;

  assign start  = tx_en && !act_q;
  assign load   = start || (tx_en && act_q && tick && (idx_q == IW'(DW - 1)));
  assign active = act_q;
  assign tx_bit = sh_q[DW-1];

  always_comb begin
    act_d = act_q;
    sh_d  = sh_q;
    idx_d = idx_q;
    if (!tx_en) begin
      act_d = 1'b0;
      sh_d  = '0;
      idx_d = '0;
    end else if (load) begin
      act_d = 1'b1;
      sh_d  = next_byte;
      idx_d = '0;
    end else if (tick) begin
      sh_d  = {sh_q[DW-2:0], 1'b0};
      idx_d = idx_q + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      sh_q  <= '0;
      idx_q <= '0;
    end else begin
      act_q <= act_d;
      sh_q  <= sh_d;
      idx_q <= idx_d;
    end
  end

  // R3
  msb_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && act_q && tick && !load) |=> (tx_bit == $past(sh_q[DW-2])));
  // R2
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !tx_bit);
endmodule

// File: rtl/tps_byte_bank.sv
module tps_byte_bank #(
  parameter int unsigned    DW       = 8,
  parameter logic [DW-1:0]  PREAMBLE = 8'hAA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_byte,
  input  logic          load,
  input  logic          flag_clr,
  output logic [DW-1:0] next_byte,
  output logic          ready,
  output logic          underrun
);
  localparam int unsigned NS = tps_pkg::TPS_SLOTS;

  logic [DW-1:0] slot_q [NS];
  logic [DW-1:0] slot_d [NS];
  logic [NS-1:0] full_q, full_d;
  logic          rd_q, rd_d, wp_q, wp_d, rdy_q, rdy_d, unr_q, unr_d;
  logic          fresh, take, stale, same, busy, ovw;

  assign fresh     = full_q[rd_q];
  assign take      = load && fresh;
  assign stale     = load && !fresh;
  assign same      = (wp_q == rd_q);
  assign busy      = full_q[wp_q] && !(take && same);
  assign ovw       = tx_en && wr_stb && busy;
  assign next_byte = fresh ? slot_q[rd_q] : slot_q[~rd_q];
  assign ready     = rdy_q;
  assign underrun  = unr_q;

  always_comb begin
    for (int i = 0; i < NS; i++) slot_d[i] = slot_q[i];
    full_d = full_q;
    rd_d   = rd_q;
    wp_d   = wp_q;
    rdy_d  = rdy_q;
    if (!tx_en) begin
      for (int i = 0; i < NS; i++) slot_d[i] = PREAMBLE;
      full_d = '1;
      rd_d   = 1'b0;
      wp_d   = 1'b0;
      rdy_d  = 1'b0;
    end else begin
      if (take) begin
        full_d[rd_q] = 1'b0;
        rd_d         = ~rd_q;
      end
      if (wr_stb) begin
        slot_d[wp_q] = wr_byte;
        full_d[wp_q] = 1'b1;
        wp_d         = ~wp_q;
      end
      if (take && !(wr_stb && same)) rdy_d = 1'b1;
      else if (wr_stb)               rdy_d = 1'b0;
    end
  end

  always_comb begin
    unr_d = unr_q;
    if (tx_en && (stale || ovw)) unr_d = 1'b1;
    else if (flag_clr)           unr_d = 1'b0;
  end

  for (genvar g = 0; g < NS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[g] <= PREAMBLE;
      else        slot_q[g] <= slot_d[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '1;
      rd_q   <= 1'b0;
      wp_q   <= 1'b0;
      rdy_q  <= 1'b0;
      unr_q  <= 1'b0;
    end else begin
      full_q <= full_d;
      rd_q   <= rd_d;
      wp_q   <= wp_d;
      rdy_q  <= rdy_d;
      unr_q  <= unr_d;
    end
  end

  // R5
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && wr_stb && !take) |=> !ready);
  // R7
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && stale) |=> underrun);
  // R2
  disable_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (!ready && (full_q == '1)));
endmodule

// File: rtl/tx_pingpong_serializer.sv
module tx_pingpong_serializer #(
  parameter int unsigned        DATA_W   = 8,
  parameter int unsigned        RATE_W   = 7,
  parameter int unsigned        BASE_DIV = tps_pkg::TPS_BASE_DIV,
  parameter int unsigned        PRE_MUL  = tps_pkg::TPS_PRE_MUL,
  parameter logic [DATA_W-1:0]  PREAMBLE = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic [RATE_W-1:0] rate_div,
  input  logic              rate_pre,
  input  logic              flag_clr,
  output logic              tx_bit,
  output logic              ready,
  output logic              underrun
);
  logic              tick, start, load, active;
  logic [DATA_W-1:0] next_byte;

  tps_bit_clock #(.RW(RATE_W), .BASE(BASE_DIV), .PRE(PRE_MUL)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(active), .start(start),
    .rate_div(rate_div), .rate_pre(rate_pre), .tick(tick)
  );

  tps_shifter #(.DW(DATA_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tick(tick),
    .next_byte(next_byte), .start(start), .load(load),
    .active(active), .tx_bit(tx_bit)
  );

  tps_byte_bank #(.DW(DATA_W), .PREAMBLE(PREAMBLE)) u_bank (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_stb(wr_stb),
    .wr_byte(wr_byte), .load(load), .flag_clr(flag_clr),
    .next_byte(next_byte), .ready(ready), .underrun(underrun)
  );
endmodule

// File: tb/sim_tx_pingpong_serializer.sv
module sim_tx_pingpong_serializer;
  logic       clk = 1'b0;
  logic       rst_n, tx_en, wr_stb, rate_pre, flag_clr;
  logic [7:0] wr_byte;
  logic [6:0] rate_div;
  logic       tx_bit, ready, underrun;
  int total = 0, bad = 0, cyc = 0, c0 = 0, per = 29;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tx_pingpong_serializer u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_stb(wr_stb), .wr_byte(wr_byte),
    .rate_div(rate_div), .rate_pre(rate_pre), .flag_clr(flag_clr),
    .tx_bit(tx_bit), .ready(ready), .underrun(underrun)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) begin @(posedge clk); #1; end
  endtask

  task automatic set_rate(input int r, input int cs);
    rate_div = 7'(r); rate_pre = cs[0];
    per = 29 * (r + 1) * (cs != 0 ? 8 : 1);
  endtask

  task automatic start_tx;
    @(negedge clk); tx_en = 1'b1;
    @(posedge clk); #1; c0 = cyc;
  endtask

  task automatic stop_tx;
    @(negedge clk); tx_en = 1'b0;
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic pulse_wr(input logic [7:0] d);
    @(negedge clk); wr_stb = 1'b1; wr_byte = d;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic wr_on_edge(input int t, input logic [7:0] d);
    wait_cyc(t - 1);
    pulse_wr(d);
  endtask

  task automatic get_byte(input int n, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wait_cyc(c0 + (n * 8 + i) * per + per / 2);
      b = {b[6:0], tx_bit};
    end
  endtask

  task automatic next_toggle(output int t);
    logic p;
    p = tx_bit;
    do begin @(posedge clk); #1; end while (tx_bit == p);
    t = cyc;
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (250000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] b;
    int t1, t2;
    rst_n = 1'b0; tx_en = 1'b0; wr_stb = 1'b0; wr_byte = '0; flag_clr = 1'b0;
    set_rate(0, 0);
    repeat (3) @(posedge clk);
    #1;
    chk("R11 tx_bit", int'(tx_bit), 0);
    chk("R11 ready", int'(ready), 0);
    chk("R11 underrun", int'(underrun), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // preamble, ordering, ready, underrun retransmit
    start_tx();
    chk("R5 ready after first load", int'(ready), 1);
    pulse_wr(8'h3C);
    chk("R5 ready cleared by write", int'(ready), 0);
    get_byte(0, b); chk("R1 byte0", int'(b), 8'hAA);
    get_byte(1, b); chk("R1 byte1", int'(b), 8'hAA);
    chk("R5 ready after slot1 freed", int'(ready), 1);
    pulse_wr(8'hC5);
    get_byte(2, b); chk("R6 byte2", int'(b), 8'h3C);
    get_byte(3, b); chk("R6 byte3", int'(b), 8'hC5);
    chk("R7 no underrun yet", int'(underrun), 0);
    get_byte(4, b); chk("R7 retransmit", int'(b), 8'hC5);
    chk("R7 underrun set", int'(underrun), 1);
    stop_tx();
    chk("R9 cleared", int'(underrun), 0);

    // R10: write coincides with load of the same slot
    start_tx();
    pulse_wr(8'h96);
    wr_on_edge(c0 + 8 * per, 8'h0F);
    chk("R10 ready stays low", int'(ready), 0);
    chk("R10 no overwrite", int'(underrun), 0);
    get_byte(1, b); chk("R10 byte1", int'(b), 8'hAA);
    get_byte(2, b); chk("R10 byte2", int'(b), 8'h96);
    get_byte(3, b); chk("R10 byte3", int'(b), 8'h0F);
    chk("R10 underrun still clear", int'(underrun), 0);
    stop_tx();

    // R8 overwrite, R9 clear and set-wins
    start_tx();
    pulse_wr(8'h81);
    pulse_wr(8'h7E);
    chk("R8 overwrite flag", int'(underrun), 1);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    chk("R9 clear", int'(underrun), 0);
    get_byte(0, b); chk("R8 byte0", int'(b), 8'hAA);
    get_byte(1, b); chk("R8 replaced byte", int'(b), 8'h7E);
    get_byte(2, b); chk("R8 byte2", int'(b), 8'h81);
    wait_cyc(c0 + 24 * per - 1);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    chk("R9 set wins over clear", int'(underrun), 1);
    get_byte(3, b); chk("R7 resend previous", int'(b), 8'h81);

    // R2 disable
    @(negedge clk); tx_en = 1'b0;
    @(posedge clk); #1;
    chk("R2 tx_bit low", int'(tx_bit), 0);
    chk("R2 ready low", int'(ready), 0);
    pulse_wr(8'h11);
    pulse_wr(8'h22);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    start_tx();
    get_byte(0, b); chk("R2 byte0 preamble", int'(b), 8'hAA);
    get_byte(1, b); chk("R2 byte1 preamble", int'(b), 8'hAA);
    get_byte(2, b); chk("R2 write ignored", int'(b), 8'hAA);
    stop_tx();

    // R3 rate sweep
    for (int cs = 0; cs < 2; cs++) begin
      for (int r = 0; r < 4; r++) begin
        set_rate(r, cs);
        start_tx();
        next_toggle(t1);
        next_toggle(t2);
        chk("R3 first bit length", t1 - c0, per);
        chk("R3 second bit length", t2 - t1, per);
        stop_tx();
      end
    end
    set_rate(127, 1);
    start_tx();
    next_toggle(t1);
    chk("R3 longest bit", t1 - c0, 29696);
    stop_tx();

    // R4 rate change mid-bit
    set_rate(0, 0);
    start_tx();
    wait_cyc(c0 + 34);
    rate_div = 7'd1;
    next_toggle(t1);
    next_toggle(t2);
    chk("R4 current bit keeps old rate", t1 - c0, 58);
    chk("R4 next bit uses new rate", t2 - t1, 58);
    stop_tx();

    summary();
    $finish;
  end
endmodule